// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time and date as thirteen 4-bit BCD digits: seconds, minutes and hours (two digits each), day of month, month and year (two digits each), and a single weekday digit. A prescaler divides a fast base strobe (`pre_tick`) by `DIV` to produce one step per second. Each step ripples through the digit chain. The chain knows each month's length and treats a year that divides by four as a leap year. Hours count in either 24-hour form or 12-hour form, and the 12-hour form carries an afternoon flag.

A host reads and writes any digit through a 4-bit index. Five control inputs shape the count:
- `hold` freezes the visible digits but remembers a second that arrives meanwhile.
- `stop` freezes the prescaler.
- `pre_clr` zeroes the prescaler.
- `mode24` selects the hour format.
- `adj` rounds the time to the nearest whole minute.

`busy` marks the last few prescaler steps before a second boundary. `locked` marks a fixed number of prescaler steps after a rounding adjust. Host writes are refused while either flag is set.

Digit index map: 0 seconds units, 1 seconds tens, 2 minutes units, 3 minutes tens, 4 hours units, 5 hours tens, 6 day units, 7 day tens, 8 month units, 9 month tens, 10 year units, 11 year tens, 12 weekday.

Top module: `cal_counter`

## Requirements
- R1: After synchronous reset, the digits read weekday 0, year 00, month 01, day 01, time 00:00:00, and both `busy` and `locked` are 0.
- R2: In 24-hour mode one second step advances seconds 00..59, minutes 00..59 and hours 00..23 with carries. An hour carry advances the day and also advances the weekday 0..6 with wrap.
- R3: In 12-hour mode, bit 2 of the hours-tens digit is the afternoon flag and bits 1:0 are the tens. Hours run 12,1..11. The flag toggles on entering 12, and the day advances only when 11 p.m. passes to 12 a.m. In 24-hour mode, bits 3:2 of the hours-tens digit read 0 and the flag is ignored when counting.
- R4: The day wraps to 01 after 31, 30 or 28 days as the month requires. February has 29 days when the binary year value is a multiple of 4 (year 00 included). The month wraps 12 to 01 and the year wraps 99 to 00.
- R5: A digit pair holding a value at or above its limit (including non-decimal nibbles) wraps to its first legal value on its next step and passes the carry on.
- R6: While `hold` is 1 the digits do not change. A second boundary reached during hold is applied in the first cycle after `hold` falls, exactly once.
- R7: While `stop` is 1, `pre_tick` does not advance the prescaler. `pre_clr` forces the prescaler to zero.
- R8: `busy` is 1 when the prescaler count is at least `DIV-BUSY_TICKS` and `hold` is 0. Host writes issued while `busy` is 1 are dropped.
- R9: On `adj`, seconds become 00. If the seconds were 30..59, the minutes also advance with the full carry chain; if they were 00..29, the minutes stay unchanged.
- R10: An accepted `adj` sets `locked` for `LOCK_TICKS` subsequent `pre_tick` pulses. While locked, host writes and further `adj` requests are dropped.
- R11: Writes to indexes 13..15 change nothing, and reads from those indexes return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pre_tick | input | 1 | Base strobe, one cycle per prescaler step |
| hold | input | 1 | Freeze visible digits, defer the second |
| stop | input | 1 | Freeze the prescaler |
| pre_clr | input | 1 | Clear the prescaler to zero |
| mode24 | input | 1 | 1 = 24-hour, 0 = 12-hour form |
| adj | input | 1 | Round-to-minute request, one cycle |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 4 | Digit index to write |
| wr_data | input | 4 | Digit value to write |
| rd_addr | input | 4 | Digit index to read |
| rd_data | output | 4 | Digit value read (combinational) |
| busy | output | 1 | Second boundary approaching |
| locked | output | 1 | Post-adjust access lockout |

## Verification
The checker watches, on every cycle, the relations between controls and the prescaler and flag state:
- `busy` stays low under hold.
- The prescaler count is frozen under stop and zero after a clear.
- `locked` rises after an accepted adjust and cannot rise without one.

The digit arithmetic cannot be expressed as such a relation, because it needs calendar knowledge. The bench's scenarios therefore cover it: month ends, leap years, 12-hour turnover, wrapping of out-of-range digits, the rounding split at 30 seconds, and deferral under hold.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int NUM_NIB = 13;

    typedef struct packed {
        logic [3:0] w;
        logic [3:0] y10;
        logic [3:0] y1;
        logic [3:0] mo10;
        logic [3:0] mo1;
        logic [3:0] d10;
        logic [3:0] d1;
        logic [3:0] h10;
        logic [3:0] h1;
        logic [3:0] mi10;
        logic [3:0] mi1;
        logic [3:0] s10;
        logic [3:0] s1;
    } cal_time_t;

    // index 0 is seconds units, index 12 is weekday
    typedef logic [NUM_NIB-1:0][3:0] nib_arr_t;

    typedef struct packed {
        logic [7:0] v;
        logic       cy;
    } step_t;

    localparam cal_time_t RESET_TIME = '{w: 4'd0, y10: 4'd0, y1: 4'd0,
                                         mo10: 4'd0, mo1: 4'd1, d10: 4'd0, d1: 4'd1,
                                         h10: 4'd0, h1: 4'd0, mi10: 4'd0, mi1: 4'd0,
                                         s10: 4'd0, s1: 4'd0};

    function automatic logic [7:0] bcd_val(input logic [3:0] t, input logic [3:0] o);
        return ({4'd0, t} * 8'd10) + {4'd0, o};
    endfunction

    function automatic logic [7:0] to_bcd(input logic [7:0] v);
        logic [3:0] tens;
        logic [3:0] ones;
        tens = 4'(v / 8'd10);
        ones = 4'(v % 8'd10);
        return {tens, ones};
    endfunction

    function automatic step_t wrap_inc(input logic [7:0] v, input logic [7:0] lo,
                                       input logic [7:0] hi);
        step_t r;
        if (v >= hi) begin
            r.v  = lo;
            r.cy = 1'b1;
        end else begin
            r.v  = v + 8'd1;
            r.cy = 1'b0;
        end
        return r;
    endfunction

    function automatic logic [7:0] month_days(input logic [7:0] m, input logic [7:0] y);
        logic [7:0] r;
        case (m)
            8'd2:                     r = (y[1:0] == 2'b00) ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11:  r = 8'd30;
            default:                  r = 8'd31;
        endcase
        return r;
    endfunction

    // One step of the digit chain. round_min starts the chain at the minutes
    // with the seconds cleared (rounding adjust).
    function automatic cal_time_t tick_time(input cal_time_t t, input logic mode24,
                                            input logic round_min);
        cal_time_t  n;
        step_t      s;
        logic       cy;
        logic       pm_n;
        logic [7:0] hr;
        logic [7:0] hr_n;
        logic [7:0] pair;
        n = t;
        if (round_min) begin
            n.s10 = 4'd0;
            n.s1  = 4'd0;
            cy    = (bcd_val(t.s10, t.s1) >= 8'd30);
        end else begin
            s  = wrap_inc(bcd_val(t.s10, t.s1), 8'd0, 8'd59);
            {n.s10, n.s1} = to_bcd(s.v);
            cy = s.cy;
        end
        if (cy) begin
            s  = wrap_inc(bcd_val(t.mi10, t.mi1), 8'd0, 8'd59);
            {n.mi10, n.mi1} = to_bcd(s.v);
            cy = s.cy;
        end
        if (cy) begin
            hr = bcd_val({2'b00, t.h10[1:0]}, t.h1);
            if (mode24) begin
                s    = wrap_inc(hr, 8'd0, 8'd23);
                pair = to_bcd(s.v);
                n.h10 = {2'b00, pair[5:4]};
                n.h1  = pair[3:0];
                cy    = s.cy;
            end else begin
                hr_n  = (hr >= 8'd12) ? 8'd1 : hr + 8'd1;
                pm_n  = t.h10[2] ^ (hr_n == 8'd12);
                cy    = (hr_n == 8'd12) && t.h10[2];
                pair  = to_bcd(hr_n);
                n.h10 = {1'b0, pm_n, pair[5:4]};
                n.h1  = pair[3:0];
            end
        end
        if (cy) begin
            s   = wrap_inc({4'd0, t.w}, 8'd0, 8'd6);
            n.w = s.v[3:0];
            s   = wrap_inc(bcd_val(t.d10, t.d1), 8'd1,
                           month_days(bcd_val(t.mo10, t.mo1), bcd_val(t.y10, t.y1)));
            {n.d10, n.d1} = to_bcd(s.v);
            cy = s.cy;
        end
        if (cy) begin
            s  = wrap_inc(bcd_val(t.mo10, t.mo1), 8'd1, 8'd12);
            {n.mo10, n.mo1} = to_bcd(s.v);
            cy = s.cy;
        end
        if (cy) begin
            s  = wrap_inc(bcd_val(t.y10, t.y1), 8'd0, 8'd99);
            {n.y10, n.y1} = to_bcd(s.v);
        end
        return n;
    endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
    parameter int DIV        = 8192,
    parameter int BUSY_TICKS = 4,
    localparam int SUB_W     = $clog2(DIV)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pre_tick,
    input  logic             stop,
    input  logic             pre_clr,
    input  logic             hold,
    output logic             sec_strobe,
    output logic             busy,
    output logic [SUB_W-1:0] sub_q
);
    localparam logic [SUB_W-1:0] LAST       = SUB_W'(DIV - 1);
    localparam logic [SUB_W-1:0] BUSY_START = SUB_W'(DIV - BUSY_TICKS);

    logic step;
    assign step = pre_tick && !stop && !pre_clr;

    always_ff @(posedge clk) begin
        if (rst || pre_clr) begin
            sub_q <= '0;
        end else if (step) begin
            sub_q <= (sub_q == LAST) ? '0 : sub_q + 1'b1;
        end
    end

    assign sec_strobe = step && (sub_q == LAST);
    assign busy       = !hold && (sub_q >= BUSY_START);
endmodule

// File: rtl/cal_lockout.sv
module cal_lockout #(
    parameter int LOCK_TICKS = 625,
    localparam int LK_W      = $clog2(LOCK_TICKS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic pre_tick,
    input  logic start,
    output logic locked
);
    logic [LK_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= LK_W'(LOCK_TICKS);
        end else if (pre_tick && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign locked = (cnt_q != '0);
endmodule

// File: rtl/cal_time_core.sv
module cal_time_core
    import cal_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      mode24,
    input  logic      inc,
    input  logic      adj_go,
    input  logic      wr_go,
    input  logic [3:0] wr_addr,
    input  logic [3:0] wr_data,
    output cal_time_t tq
);
    nib_arr_t  wr_view;
    cal_time_t nxt;

    always_comb begin
        wr_view = nib_arr_t'(tq);
        if (wr_addr < 4'(NUM_NIB)) begin
            wr_view[wr_addr] = wr_data;
        end
        // priority: rounding adjust, then second step, then host write
        if (adj_go) begin
            nxt = tick_time(tq, mode24, 1'b1);
        end else if (inc) begin
            nxt = tick_time(tq, mode24, 1'b0);
        end else if (wr_go) begin
            nxt = cal_time_t'(wr_view);
        end else begin
            nxt = tq;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tq <= RESET_TIME;
        end else begin
            tq <= nxt;
        end
    end
endmodule

// File: rtl/cal_counter.sv
module cal_counter
    import cal_pkg::*;
#(
    parameter int DIV        = 8192,
    parameter int BUSY_TICKS = 4,
    parameter int LOCK_TICKS = 625
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pre_tick,
    input  logic       hold,
    input  logic       stop,
    input  logic       pre_clr,
    input  logic       mode24,
    input  logic       adj,
    input  logic       wr_en,
    input  logic [3:0] wr_addr,
    input  logic [3:0] wr_data,
    input  logic [3:0] rd_addr,
    output logic [3:0] rd_data,
    output logic       busy,
    output logic       locked
);
    localparam int SUB_W = $clog2(DIV);

    logic             sec_strobe;
    logic [SUB_W-1:0] sub_q;
    logic             pend_q;
    logic             adj_go;
    logic             inc;
    logic             wr_go;
    cal_time_t        tq;
    nib_arr_t         rd_view;

    cal_prescaler #(.DIV(DIV), .BUSY_TICKS(BUSY_TICKS)) u_pre (
        .clk(clk), .rst(rst), .pre_tick(pre_tick), .stop(stop), .pre_clr(pre_clr),
        .hold(hold), .sec_strobe(sec_strobe), .busy(busy), .sub_q(sub_q)
    );

    cal_lockout #(.LOCK_TICKS(LOCK_TICKS)) u_lock (
        .clk(clk), .rst(rst), .pre_tick(pre_tick), .start(adj_go), .locked(locked)
    );

    assign adj_go = adj && !locked;
    assign inc    = !hold && !adj_go && (sec_strobe || pend_q);
    assign wr_go  = wr_en && !locked && !busy && (wr_addr < 4'(NUM_NIB));

    // a second that cannot be applied now is kept for later
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else if (hold || adj_go) begin
            pend_q <= pend_q || sec_strobe;
        end else begin
            pend_q <= pend_q && sec_strobe;
        end
    end

    cal_time_core u_core (
        .clk(clk), .rst(rst), .mode24(mode24), .inc(inc), .adj_go(adj_go),
        .wr_go(wr_go), .wr_addr(wr_addr), .wr_data(wr_data), .tq(tq)
    );

    always_comb begin
        rd_view = nib_arr_t'(tq);
        rd_view[5] = {1'b0, tq.h10[2] && !mode24, tq.h10[1:0]};
        if (rd_addr < 4'(NUM_NIB)) begin
            rd_data = rd_view[rd_addr];
        end else begin
            rd_data = 4'd0;
        end
    end
endmodule

// File: rtl/cal_counter_chk.sv
module cal_counter_chk #(
    parameter int SUB_W = 13
) (
    input logic             clk,
    input logic             rst,
    input logic             hold,
    input logic             stop,
    input logic             pre_clr,
    input logic             adj,
    input logic             busy,
    input logic             locked,
    input logic [SUB_W-1:0] sub_q
);
    AST_RESET_CLEAN: assert property (@(posedge clk) rst |=> (!locked && !busy)); // R1
    AST_HOLD_NO_BUSY: assert property (@(posedge clk) disable iff (rst) hold |-> !busy); // R8
    AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (stop && !pre_clr) |=> $stable(sub_q)); // R7
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
        pre_clr |=> (sub_q == '0)); // R7
    AST_ADJ_LOCKS: assert property (@(posedge clk) disable iff (rst)
        (adj && !locked) |=> locked); // R10
    AST_LOCK_NEEDS_ADJ: assert property (@(posedge clk) disable iff (rst)
        (!locked && !adj) |=> !locked); // R10
endmodule

bind cal_counter cal_counter_chk #(.SUB_W(SUB_W)) u_chk (
    .clk(clk), .rst(rst), .hold(hold), .stop(stop), .pre_clr(pre_clr), .adj(adj),
    .busy(busy), .locked(locked), .sub_q(sub_q)
);

// File: tb/cal_counter_tb.sv
module cal_counter_tb;
    localparam int DIV  = 8;
    localparam int BUSY = 2;
    localparam int LOCK = 5;
    localparam int NV   = 13;

    // {mode24, start, expected after one second}; digits W Y10 Y1 MO10 MO1 D10 D1 H10 H1 MI10 MI1 S10 S1
    localparam logic [104:0] VEC [NV] = '{
        {1'b1, 52'h0240315101234, 52'h0240315101235},  // R2 plain
        {1'b1, 52'h0240315101259, 52'h0240315101300},  // R2 minute carry
        {1'b1, 52'h6991231235959, 52'h0000101000000},  // R2 R4 full rollover
        {1'b1, 52'h2230228235959, 52'h3230301000000},  // R4 common February
        {1'b1, 52'h2240228235959, 52'h3240229000000},  // R4 leap February
        {1'b1, 52'h3240229235959, 52'h4240301000000},  // R4 leap day end
        {1'b1, 52'h1250430235959, 52'h2250501000000},  // R4 30-day month
        {1'b1, 52'h0000228235959, 52'h1000229000000},  // R4 year 00 leap
        {1'b0, 52'h0240315115959, 52'h0240315520000},  // R3 11am to 12pm
        {1'b0, 52'h1240131515959, 52'h2240201120000},  // R3 11pm to 12am, day
        {1'b0, 52'h0240315525959, 52'h0240315410000},  // R3 12pm to 1pm
        {1'b1, 52'h024031510125C, 52'h0240315101300},  // R5 bad seconds digit
        {1'b1, 52'h0240315400000, 52'h0240315000001}   // R3 flag masked in 24h
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pre_tick = 1'b0, hold = 1'b0, stop = 1'b0, pre_clr = 1'b0;
    logic       mode24 = 1'b1, adj = 1'b0, wr_en = 1'b0;
    logic [3:0] wr_addr = 4'd0, wr_data = 4'd0, rd_addr = 4'd0;
    logic [3:0] rd_data;
    logic       busy, locked;
    int         n_tests = 0;
    int         n_fail  = 0;
    logic [51:0] got;

    always #5 clk = ~clk;

    cal_counter #(.DIV(DIV), .BUSY_TICKS(BUSY), .LOCK_TICKS(LOCK)) u_dut (
        .clk(clk), .rst(rst), .pre_tick(pre_tick), .hold(hold), .stop(stop),
        .pre_clr(pre_clr), .mode24(mode24), .adj(adj), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .locked(locked)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [3:0] a, input logic [3:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_pre(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); pre_tick = 1'b1;
            @(negedge clk); pre_tick = 1'b0;
        end
    endtask

    task automatic pulse_adj();
        @(negedge clk); adj = 1'b1;
        @(negedge clk); adj = 1'b0;
    endtask

    task automatic read_all(output logic [51:0] t);
        for (int i = 0; i < 13; i++) begin
            rd_addr = 4'(i);
            #1;
            t[4*i +: 4] = rd_data;
        end
    endtask

    task automatic load_time(input logic [51:0] t);
        @(negedge clk); hold = 1'b1; pre_clr = 1'b1;
        @(negedge clk); pre_clr = 1'b0;
        for (int i = 0; i < 13; i++) do_write(4'(i), t[4*i +: 4]);
        @(negedge clk); hold = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        read_all(got);
        check("R1 reset digits", 64'(got), 64'(52'h0000101000000));
        check("R1 reset flags", {62'd0, busy, locked}, 64'd0);

        for (int v = 0; v < NV; v++) begin
            mode24 = VEC[v][104];
            load_time(VEC[v][103:52]);
            pulse_pre(DIV);
            @(negedge clk);
            read_all(got);
            check($sformatf("R2-R5 vector %0d", v), 64'(got), 64'(VEC[v][51:0]));
        end
        mode24 = 1'b1;

        // R6 hold defers one second
        load_time(52'h0240315101234);
        @(negedge clk); hold = 1'b1;
        pulse_pre(DIV);
        @(negedge clk);
        read_all(got);
        check("R6 frozen under hold", 64'(got), 64'(52'h0240315101234));
        hold = 1'b0;
        @(negedge clk);
        @(negedge clk);
        read_all(got);
        check("R6 applied once after hold", 64'(got), 64'(52'h0240315101235));

        // R7 stop
        load_time(52'h0240315101234);
        @(negedge clk); stop = 1'b1;
        pulse_pre(DIV);
        @(negedge clk); stop = 1'b0;
        read_all(got);
        check("R7 stop freezes", 64'(got), 64'(52'h0240315101234));
        pulse_pre(DIV);
        @(negedge clk);
        read_all(got);
        check("R7 resumes after stop", 64'(got), 64'(52'h0240315101235));

        // R7 prescaler clear
        load_time(52'h0240315101234);
        pulse_pre(DIV - 2);
        @(negedge clk); pre_clr = 1'b1;
        @(negedge clk); pre_clr = 1'b0;
        pulse_pre(2);
        @(negedge clk);
        read_all(got);
        check("R7 clear restarts prescaler", 64'(got), 64'(52'h0240315101234));

        // R8 busy window
        load_time(52'h0240315101234);
        pulse_pre(DIV - BUSY - 1);
        @(negedge clk);
        check("R8 busy low before window", {63'd0, busy}, 64'd0);
        pulse_pre(1);
        @(negedge clk);
        check("R8 busy high in window", {63'd0, busy}, 64'd1);
        do_write(4'd0, 4'd9);
        rd_addr = 4'd0; #1;
        check("R8 write dropped while busy", {60'd0, rd_data}, 64'd4);
        hold = 1'b1; #1;
        check("R8 busy low under hold", {63'd0, busy}, 64'd0);
        @(negedge clk); hold = 1'b0;
        pulse_pre(BUSY);
        @(negedge clk);
        read_all(got);
        check("R8 second after window", 64'(got), 64'(52'h0240315101235));

        // R9 R10 rounding adjust and lockout
        load_time(52'h0240315101229);
        pulse_adj();
        read_all(got);
        check("R9 round down at 29", 64'(got), 64'(52'h0240315101200));
        check("R10 locked after adjust", {63'd0, locked}, 64'd1);
        do_write(4'd2, 4'd7);
        read_all(got);
        check("R10 write dropped while locked", 64'(got), 64'(52'h0240315101200));
        pulse_pre(LOCK - 1);
        @(negedge clk);
        check("R10 still locked", {63'd0, locked}, 64'd1);
        pulse_pre(1);
        @(negedge clk);
        check("R10 lock expires", {63'd0, locked}, 64'd0);

        load_time(52'h0240315101230);
        pulse_adj();
        read_all(got);
        check("R9 round up at 30", 64'(got), 64'(52'h0240315101300));
        pulse_pre(LOCK);

        load_time(52'h2230228235945);
        pulse_adj();
        read_all(got);
        check("R9 round with full carry", 64'(got), 64'(52'h3230301000000));
        pulse_pre(LOCK);

        // R11 unused indexes
        load_time(52'h0240315101234);
        @(negedge clk); hold = 1'b1;
        do_write(4'd13, 4'd5);
        do_write(4'd15, 4'd9);
        rd_addr = 4'd13; #1;
        check("R11 unused index reads 0", {60'd0, rd_data}, 64'd0);
        read_all(got);
        check("R11 unused write no effect", 64'(got), 64'(52'h0240315101234));
        hold = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule